// File: doc/BRIEF.md
# Excess-One Carry Select Adder

This block is a purely combinational 16-bit adder of the square-root carry select kind. It adds two 16-bit operands and a carry-in and returns a 16-bit sum with a carry-out. The operand width is cut into five groups that widen towards the most significant end: 2, 2, 3, 4 and 5 bits. The lowest group is a plain ripple adder fed by the external carry-in.

Each upper group computes its sum only once, assuming an incoming carry of zero. An (n+1)-bit increment converter turns that carry-zero result, including its carry-out, into the carry-one result. A per-bit 2:1 multiplexer then picks one of the two once the real incoming carry is known. The selected top bit of every group is the carry into the next group. A small control module resolves that carry chain and hands the datapath one select strobe per upper group.

Full adders are each built from two half adders. There are no registers: the block sits inside a larger timing path of the chip.

Top module: `csa_adder`

## Requirements
- R1: For every operand pair and both carry-in values, {carryOut, sum} equals opA + opB + carryIn taken modulo 2^17.
- R2: The 16 bits form five groups of widths 2, 2, 3, 4 and 5 from the least significant end, so the group boundaries sit at bits 2, 4, 7 and 11. Sum bits [1:0] come from a ripple adder fed by carryIn.
- R3: When the carry into an upper group of width n is 1, the group's sum slice is the (n+1)-bit value {carry-zero carry-out, carry-zero sum} plus one. An all-ones value wraps the slice to zero and passes a carry of 1 into the next group.
- R4: When the carry into an upper group is 0, the group's sum slice equals the group's opA slice plus opB slice modulo 2^n.
- R5: The carry into each upper group is the selected top bit of the group below it, and carryOut is the selected top bit of the last group. A carry made at any group boundary therefore reaches the next group.
- R6: 0x0000 + 0x0000 with carryIn 0 gives sum 0x0000 and carryOut 0.
- R7: 0xFFFF + 0x0001 with carryIn 0 gives sum 0x0000 and carryOut 1.
- R8: 0xFFFF + 0xFFFF with carryIn 1 gives sum 0xFFFF and carryOut 1.
- R9: 0xFFFF + 0x0000 with carryIn 1 carries through every group, giving sum 0x0000 and carryOut 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 16 | First operand |
| opB | input | 16 | Second operand |
| carryIn | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits |
| carryOut | output | 1 | Carry out of bit 15 |

## Verification
Every result of this block is due in the same cycle as its stimulus, because no register lies between the operand ports and sum or carryOut. The bench drives operands just after a falling clock edge. It waits one nanosecond for the adder to settle and compares the outputs before the next rising edge, so each check sees only the vector just applied. Directed vectors put carries on every group boundary and drive all-ones groups to make each converter wrap. The remaining vectors come from seeded random operands, some biased towards long runs of ones.

// File: rtl/csa_pkg.sv
package csa_pkg;

  // overall operand width and the width of the lowest ripple group
  localparam int unsigned SUM_W   = 16;
  localparam int unsigned FIRST_W = 2;

  // width of group g before truncation: FIRST_W, FIRST_W, FIRST_W+1, ...
  function automatic int unsigned rawWidth(input int unsigned g);
    return (g == 0) ? FIRST_W : FIRST_W + g - 1;
  endfunction

  function automatic int unsigned grpBase(input int unsigned g);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < g; k++) acc += rawWidth(k);
    return acc;
  endfunction

  // last group is cut so the groups exactly cover SUM_W
  function automatic int unsigned grpWidth(input int unsigned g);
    int unsigned room;
    room = SUM_W - grpBase(g);
    return (rawWidth(g) > room) ? room : rawWidth(g);
  endfunction

  function automatic int unsigned countGroups();
    int unsigned n;
    n = 0;
    while (grpBase(n) < SUM_W) n++;
    return n;
  endfunction

  localparam int unsigned NUM_GRP = countGroups();

  // strobes from the carry control to the datapath: one select per upper group
  typedef struct packed {
    logic [NUM_GRP-2:0] useInc;
  } sel_strobes_t;

endpackage

// File: rtl/csa_half_adder.sv
module csa_half_adder (
  input  logic x,
  input  logic y,
  output logic s,
  output logic c
);
  assign s = x ^ y;
  assign c = x & y;
endmodule

// File: rtl/csa_full_adder.sv
module csa_full_adder (
  input  logic a,
  input  logic b,
  input  logic cin,
  output logic s,
  output logic cout
);
  logic s1;
  logic c1;
  logic c2;

  csa_half_adder i_ha0 (.x(a),  .y(b),   .s(s1), .c(c1));
  csa_half_adder i_ha1 (.x(s1), .y(cin), .s(s),  .c(c2));

  assign cout = c1 | c2;
endmodule

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] chain;

  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    csa_full_adder i_fa (
      .a(a[i]), .b(b[i]), .cin(chain[i]),
      .s(s[i]), .cout(chain[i+1])
    );
  end

  assign cout = chain[W];
endmodule

// File: rtl/csa_excess_one.sv
module csa_excess_one #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  assign y[0] = ~x[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign y[i] = x[i] ^ (&x[i-1:0]);
  end
endmodule

// File: rtl/csa_datapath.sv
module csa_datapath
  import csa_pkg::*;
(
  input  logic [SUM_W-1:0]   opA,
  input  logic [SUM_W-1:0]   opB,
  input  logic               carryIn,
  input  sel_strobes_t       strobes,
  output logic [SUM_W-1:0]   sum,
  output logic [NUM_GRP-1:0] rawTop,
  output logic [NUM_GRP-1:1] incTop
);
  localparam int unsigned W0 = grpWidth(0);

  // lowest group: plain ripple adder on the external carry
  csa_ripple #(.W(W0)) i_lowRipple (
    .a(opA[W0-1:0]), .b(opB[W0-1:0]), .cin(carryIn),
    .s(sum[W0-1:0]), .cout(rawTop[0])
  );

  for (genvar g = 1; g < NUM_GRP; g++) begin : g_grp
    localparam int unsigned B = grpBase(g);
    localparam int unsigned W = grpWidth(g);

    logic [W-1:0] zeroSum;
    logic         zeroCarry;
    logic [W:0]   incVal;

    csa_ripple #(.W(W)) i_ripple (
      .a(opA[B+W-1:B]), .b(opB[B+W-1:B]), .cin(1'b0),
      .s(zeroSum), .cout(zeroCarry)
    );

    csa_excess_one #(.W(W+1)) i_inc (
      .x({zeroCarry, zeroSum}),
      .y(incVal)
    );

    assign sum[B+W-1:B] = strobes.useInc[g-1] ? incVal[W-1:0] : zeroSum;
    assign rawTop[g]    = zeroCarry;
    assign incTop[g]    = incVal[W];
  end
endmodule

// File: rtl/csa_carry_ctrl.sv
module csa_carry_ctrl
  import csa_pkg::*;
(
  input  logic [NUM_GRP-1:0] rawTop,
  input  logic [NUM_GRP-1:1] incTop,
  output sel_strobes_t       strobes,
  output logic               carryOut
);
  // walk the group carries from the lowest group upward
  always_comb begin
    logic grpCarry;
    grpCarry = rawTop[0];
    strobes  = '0;
    for (int g = 1; g < int'(NUM_GRP); g++) begin
      strobes.useInc[g-1] = grpCarry;
      grpCarry = grpCarry ? incTop[g] : rawTop[g];
    end
    carryOut = grpCarry;
  end
endmodule

// File: rtl/csa_adder.sv
module csa_adder
  import csa_pkg::*;
(
  input  logic [SUM_W-1:0] opA,
  input  logic [SUM_W-1:0] opB,
  input  logic             carryIn,
  output logic [SUM_W-1:0] sum,
  output logic             carryOut
);
  sel_strobes_t       strobes;
  logic [NUM_GRP-1:0] rawTop;
  logic [NUM_GRP-1:1] incTop;

  csa_datapath i_datapath (
    .opA(opA), .opB(opB), .carryIn(carryIn), .strobes(strobes),
    .sum(sum), .rawTop(rawTop), .incTop(incTop)
  );

  csa_carry_ctrl i_ctrl (
    .rawTop(rawTop), .incTop(incTop),
    .strobes(strobes), .carryOut(carryOut)
  );
endmodule

// File: rtl/csa_checker.sv
module csa_checker
  import csa_pkg::*;
(
  input logic [SUM_W-1:0] opA,
  input logic [SUM_W-1:0] opB,
  input logic             carryIn,
  input logic [SUM_W-1:0] sum,
  input logic             carryOut,
  input sel_strobes_t     strobes
);
  always_comb begin
    logic [SUM_W:0] total;
    logic [SUM_W:0] lowMask;
    logic [SUM_W:0] lowSum;
    logic [SUM_W:0] sliceMask;
    logic [SUM_W:0] sliceGot;
    logic [SUM_W:0] sliceZero;
    total = {1'b0, opA} + {1'b0, opB} + {{SUM_W{1'b0}}, carryIn};

    AST_SUM_EXACT: assert ({carryOut, sum} == total)
      else $error("sum mismatch");  // R1
    AST_LOW_GROUP: assert (sum[1:0] == 2'(opA[1:0] + opB[1:0] + {1'b0, carryIn}))
      else $error("low group mismatch");  // R2

    for (int g = 1; g < int'(NUM_GRP); g++) begin
      lowMask   = (({{SUM_W{1'b0}}, 1'b1}) << grpBase(g)) - 1'b1;
      lowSum    = ({1'b0, opA} & lowMask) + ({1'b0, opB} & lowMask)
                + {{SUM_W{1'b0}}, carryIn};
      sliceMask = (({{SUM_W{1'b0}}, 1'b1}) << grpWidth(g)) - 1'b1;
      sliceGot  = ({1'b0, sum} >> grpBase(g)) & sliceMask;
      sliceZero = ((({1'b0, opA} >> grpBase(g)) & sliceMask)
                 + (({1'b0, opB} >> grpBase(g)) & sliceMask)) & sliceMask;
      AST_SEL_CARRY: assert (strobes.useInc[g-1] == lowSum[grpBase(g)])
        else $error("group select differs from carry");  // R5
      if (!strobes.useInc[g-1]) begin
        AST_ZERO_PATH: assert (sliceGot == sliceZero)
          else $error("carry-zero slice wrong");  // R4
      end else begin
        AST_INC_PATH: assert (sliceGot == ((sliceZero + 1'b1) & sliceMask))
          else $error("carry-one slice wrong");  // R3
      end
    end
  end
endmodule

bind csa_adder csa_checker i_checker (
  .opA(opA), .opB(opB), .carryIn(carryIn),
  .sum(sum), .carryOut(carryOut), .strobes(strobes)
);

// File: tb/test_csa_adder.sv
module test_csa_adder;
  logic        clk = 1'b0;
  logic [15:0] opA = '0;
  logic [15:0] opB = '0;
  logic        carryIn = 1'b0;
  logic [15:0] sum;
  logic        carryOut;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  // group boundaries from R2
  int          bases[4] = '{2, 4, 7, 11};
  int          tops[4]  = '{4, 7, 11, 16};

  always #2 clk = ~clk;

  csa_adder i_csa_adder (
    .opA(opA), .opB(opB), .carryIn(carryIn),
    .sum(sum), .carryOut(carryOut)
  );

  function automatic logic [16:0] refAdd(logic [15:0] a, logic [15:0] b, logic c);
    return {1'b0, a} + {1'b0, b} + {16'd0, c};
  endfunction

  task automatic applyCheck(input logic [15:0] a, input logic [15:0] b,
                            input logic c, input logic [16:0] exp, input string req);
    @(negedge clk);
    opA = a; opB = b; carryIn = c;
    #1;
    total++;
    if ({carryOut, sum} !== exp) begin
      bad++;
      $display("FAIL %s a=%h b=%h cin=%b got=%h expected=%h",
               req, a, b, c, {carryOut, sum}, exp);
    end
  endtask

  initial begin
    #700000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] a;
    logic [15:0] b;
    logic        c;
    void'($urandom(32'h1A2B3C4D));

    // corner cases
    applyCheck(16'h0000, 16'h0000, 1'b0, 17'h00000, "R6");
    applyCheck(16'hFFFF, 16'h0001, 1'b0, 17'h10000, "R7");
    applyCheck(16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF, "R8");
    applyCheck(16'hFFFF, 16'h0000, 1'b1, 17'h10000, "R9");

    // low ripple group fed by carryIn
    applyCheck(16'h0003, 16'h0000, 1'b1, 17'h00004, "R2");
    applyCheck(16'h0001, 16'h0002, 1'b0, 17'h00003, "R2");
    applyCheck(16'h0002, 16'h0001, 1'b1, 17'h00004, "R2");

    for (int g = 0; g < 4; g++) begin
      // R5: carry produced just below a boundary enters the next group
      a = 16'((17'd1 << bases[g]) - 1);
      applyCheck(a, 16'h0001, 1'b0, refAdd(a, 16'h0001, 1'b0), "R5");
      // R3: whole group plus everything below all ones, carry 1 in: group wraps
      a = 16'((17'd1 << tops[g]) - 1);
      applyCheck(a, 16'h0000, 1'b1, refAdd(a, 16'h0000, 1'b1), "R3");
      // R3: group slice 1 with incoming carry 1 becomes 2
      a = 16'((17'd1 << bases[g]) | ((17'd1 << bases[g]) - 1));
      applyCheck(a, 16'h0000, 1'b1, refAdd(a, 16'h0000, 1'b1), "R3");
      // R4: same slice, no incoming carry, passes a+b unchanged
      a = 16'(17'd3 << bases[g]);
      b = 16'(17'd1 << bases[g]);
      applyCheck(a, b, 1'b0, refAdd(a, b, 1'b0), "R4");
    end
    applyCheck(16'h8000, 16'h8000, 1'b0, 17'h10000, "R5");

    // random operands, some biased towards long runs of ones
    for (int n = 0; n < 3000; n++) begin
      a = 16'($urandom);
      b = 16'($urandom);
      c = 1'($urandom);
      if (n % 3 == 1) a = a | 16'($urandom);
      if (n % 3 == 2) b = ~a ^ 16'(1 << ($urandom % 16));
      applyCheck(a, b, c, refAdd(a, b, c), "R1");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule